// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, out of a bank of programmable priority slots, the most urgent active interrupt source for each of two delivery classes: the fast class (FIQ) and the normal class (IRQ). Each slot names one source by a 6-bit ID and carries a valid flag. Urgency is set by where a source is placed, not by its number. Slot 0 is the most urgent, and software may put any source into any slot.

The resolver receives the slot words as a flat vector, together with two flat per-source vectors. One says which sources are currently enabled and pending. The other says which sources are classified as fast. It resolves both classes independently and packs the two winners into one 32-bit status word, each half with its own valid flag. The status word is held in a register, so the value seen at the output always comes from inputs captured on one clock edge. Register storage for the slots and bus decoding sit outside this block.

Top module: `prio_resolver`

## Requirements
- R1: In each 32-bit slot word, only bit 31 (valid flag) and bits 5:0 (source ID) have an effect; all other slot bits are ignored.
- R2: A slot takes part only when its valid flag is set and its ID is below NUM_SRCS (40); any other slot is skipped, so a reported ID is always below 40.
- R3: Among the slots that qualify for a class, the one with the lowest slot index wins, whatever the source numbers are.
- R4: A slot qualifies for the FIQ result when its source's bit in `src_active` is 1 and its bit in `src_is_fiq` is 1. It qualifies for the IRQ result when the active bit is 1 and the fast bit is 0. The two classes are resolved independently.
- R5: The FIQ result sits in the low half of `status_word`: bit 15 is its valid flag and bits 5:0 are the winning ID.
- R6: The IRQ result sits in the high half of `status_word`: bit 31 is its valid flag and bits 21:16 are the winning ID.
- R7: A class with no winner shows 0x003F in its half: the valid flag is 0 and the ID field is all ones.
- R8: Source ID s maps to bit s of the flat source vectors. Bits 31:0 form bank 0 (IDs 0 to 31), and bit (s-32) of bank 1 lies at bit s (IDs 32 to 39).
- R9: Bits 30:22 and 14:6 of `status_word` always read 0.
- R10: `status_word` is updated on the rising clock edge after the inputs are presented. While `rst_n` is low, it reads 0x003F003F on the next edge.
- R11: When two slots hold the same source ID, the lower slot wins and the reported ID is that single source ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_cfg | input | NUM_SLOTS*32 (1280) | Slot words; slot k occupies bits 32k+31:32k |
| src_active | input | NUM_BANKS*BANK_W (64) | Enabled-and-pending flag per source ID |
| src_is_fiq | input | NUM_BANKS*BANK_W (64) | Class per source ID: 1 = FIQ, 0 = IRQ |
| status_word | output | 32 | Packed winners: IRQ half in 31:16, FIQ half in 15:0 |

## Verification
FIQ and IRQ resolution run in the same cycle over the same slot list, so both halves can carry a winner at once. One source's class bit must not leak into the other half. Table rows drive both classes active together: in some rows the two winners come from adjacent slots, and in others a fast-class source sits above a normal-class one. Each row's check compares the whole 32-bit word, so a winner misplaced into the wrong half, or missing from either half, is reported. A slot-by-slot scan and the range and validity cases check the ordering and skipping rules.

// File: rtl/prio_resolver_pkg.sv
// Package: prio_resolver_pkg
// Shared field positions, the per-class winner type and the half-word
// packing rule for the priority interrupt resolver. It assumes source IDs
// fit in ID_W bits and that the two halves of the status word share one
// layout.
package prio_resolver_pkg;

    localparam int SLOT_W         = 32;
    localparam int SLOT_VALID_BIT = 31;
    localparam int ID_W           = 6;
    localparam int HALF_W         = 16;
    localparam int HALF_FLAG_BIT  = 15;
    localparam int NUM_CLASSES    = 2;
    localparam int CLASS_FIQ      = 0;
    localparam int CLASS_IRQ      = 1;

    localparam logic [HALF_W-1:0] IDLE_HALF = {{(HALF_W-ID_W){1'b0}}, {ID_W{1'b1}}};

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] id;
    } winner_t;

    // Build one 16-bit half: flag on top bit, ID in the low bits, idle code otherwise.
    function automatic logic [HALF_W-1:0] pack_half(input winner_t w);
        logic [HALF_W-1:0] h;
        if (w.found) begin
            h                = '0;
            h[HALF_FLAG_BIT] = 1'b1;
            h[ID_W-1:0]      = w.id;
        end else begin
            h = IDLE_HALF;
        end
        return h;
    endfunction

endpackage

// File: rtl/prio_slot_decode.sv
// Module: prio_slot_decode
// Splits each slot word into its source ID and decides, for every slot,
// whether it qualifies for the FIQ class and for the IRQ class. It assumes
// that source ID s sits at bit s of the flat source vectors and that
// NUM_SRCS does not exceed the width of those vectors.
module prio_slot_decode
    import prio_resolver_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int NUM_SRCS  = 40,
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 2
) (
    input  logic [NUM_SLOTS*SLOT_W-1:0]  slot_cfg,
    input  logic [NUM_BANKS*BANK_W-1:0]  src_active,
    input  logic [NUM_BANKS*BANK_W-1:0]  src_is_fiq,
    output logic [NUM_SLOTS*ID_W-1:0]    slot_id,
    output logic [NUM_SLOTS-1:0]         fiq_hit,
    output logic [NUM_SLOTS-1:0]         irq_hit
);

    localparam int SRC_VEC_W = NUM_BANKS * BANK_W;
    localparam int VEC_IDX_W = (SRC_VEC_W > 1) ? $clog2(SRC_VEC_W) : 1;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [ID_W-1:0]      id_f;
        logic                 valid_f;
        logic                 in_range;
        logic [VEC_IDX_W-1:0] vec_idx;
        logic                 act_b;
        logic                 fast_b;

        // Pull the valid flag and the ID field out of this slot word.
        always_comb begin
            id_f    = slot_cfg[s*SLOT_W +: ID_W];
            valid_f = slot_cfg[s*SLOT_W + SLOT_VALID_BIT];
        end

        // Check the range and look the source up in the flat vectors.
        always_comb begin
            in_range = (int'(id_f) < NUM_SRCS);
            vec_idx  = VEC_IDX_W'(id_f);
            act_b    = in_range ? src_active[vec_idx] : 1'b0;
            fast_b   = in_range ? src_is_fiq[vec_idx] : 1'b0;
        end

        // Decide whether the slot takes part in each class.
        always_comb begin
            fiq_hit[s] = valid_f & act_b &  fast_b;
            irq_hit[s] = valid_f & act_b & ~fast_b;
        end

        assign slot_id[s*ID_W +: ID_W] = id_f;
    end

endmodule

// File: rtl/prio_first_pick.sv
// Module: prio_first_pick
// Returns the ID held by the lowest-indexed slot whose hit bit is set. It
// assumes the hit bits have already been qualified by the slot decoder.
module prio_first_pick
    import prio_resolver_pkg::*;
#(
    parameter int NUM_SLOTS = 40
) (
    input  logic [NUM_SLOTS-1:0]      hit,
    input  logic [NUM_SLOTS*ID_W-1:0] slot_id,
    output winner_t                   winner
);

    // Scan from the least urgent slot to the most urgent; the last hit seen stays.
    always_comb begin
        winner.found = 1'b0;
        winner.id    = '1;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (hit[s]) begin
                winner.found = 1'b1;
                winner.id    = slot_id[s*ID_W +: ID_W];
            end
        end
    end

endmodule

// File: rtl/prio_resolver.sv
// Module: prio_resolver (top)
// Resolves the most urgent active source for the FIQ and the IRQ class from
// the programmable slots and holds both results, packed, in a status
// register. It assumes the inputs are stable for the setup window before each
// rising edge. Reset is synchronous and active low.
module prio_resolver
    import prio_resolver_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int NUM_SRCS  = 40,
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS*SLOT_W-1:0]   slot_cfg,
    input  logic [NUM_BANKS*BANK_W-1:0]   src_active,
    input  logic [NUM_BANKS*BANK_W-1:0]   src_is_fiq,
    output logic [2*HALF_W-1:0]           status_word
);

    localparam logic [2*HALF_W-1:0] IDLE_WORD = {IDLE_HALF, IDLE_HALF};

    logic [NUM_SLOTS*ID_W-1:0] slot_id;
    logic [NUM_SLOTS-1:0]      hits [NUM_CLASSES];
    winner_t                   wins [NUM_CLASSES];
    logic [2*HALF_W-1:0]       status_next;

    prio_slot_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SRCS  (NUM_SRCS),
        .BANK_W    (BANK_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_decode (
        .slot_cfg   (slot_cfg),
        .src_active (src_active),
        .src_is_fiq (src_is_fiq),
        .slot_id    (slot_id),
        .fiq_hit    (hits[CLASS_FIQ]),
        .irq_hit    (hits[CLASS_IRQ])
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        prio_first_pick #(
            .NUM_SLOTS (NUM_SLOTS)
        ) u_pick (
            .hit     (hits[c]),
            .slot_id (slot_id),
            .winner  (wins[c])
        );
    end

    // Put the IRQ winner in the upper half and the FIQ winner in the lower half.
    always_comb begin
        status_next = {pack_half(wins[CLASS_IRQ]), pack_half(wins[CLASS_FIQ])};
    end

    // Hold the packed result; reset to the no-winner code in both halves.
    always_ff @(posedge clk) begin
        if (!rst_n) status_word <= IDLE_WORD;
        else        status_word <= status_next;
    end

endmodule

// File: rtl/prio_resolver_chk.sv
// Module: prio_resolver_chk
// Assertion checker for prio_resolver, bound to every instance of it. It
// watches only the ports of the block.
module prio_resolver_chk
    import prio_resolver_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int NUM_SRCS  = 40,
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_SLOTS*SLOT_W-1:0]   slot_cfg,
    input logic [NUM_BANKS*BANK_W-1:0]   src_active,
    input logic [NUM_BANKS*BANK_W-1:0]   src_is_fiq,
    input logic [2*HALF_W-1:0]           status_word
);

    localparam int SRC_VEC_W = NUM_BANKS * BANK_W;
    localparam int VEC_IDX_W = (SRC_VEC_W > 1) ? $clog2(SRC_VEC_W) : 1;

    logic [ID_W-1:0]      top_id;
    logic [VEC_IDX_W-1:0] top_idx;
    logic                 top_ok;
    logic                 top_fiq;
    logic                 top_irq;

    // Work out independently whether slot 0 must win one of the classes.
    always_comb begin
        top_id  = slot_cfg[ID_W-1:0];
        top_idx = VEC_IDX_W'(top_id);
        top_ok  = slot_cfg[SLOT_VALID_BIT] && (int'(top_id) < NUM_SRCS) && src_active[top_idx];
        top_fiq = top_ok &&  src_is_fiq[top_idx];
        top_irq = top_ok && !src_is_fiq[top_idx];
    end

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[30:22] == '0) && (status_word[14:6] == '0));

    p_fiq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[15] |-> (status_word[5:0] == 6'h3F));

    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[31] |-> (status_word[21:16] == 6'h3F));

    p_fiq_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] |-> (int'(status_word[5:0]) < NUM_SRCS));

    p_irq_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[31] |-> (int'(status_word[21:16]) < NUM_SRCS));

    // R3 with R5: a qualifying slot 0 always wins the FIQ half on the next edge.
    p_slot0_fiq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        top_fiq |=> (status_word[15] && (status_word[5:0] == $past(top_id))));

    // R3 with R6: a qualifying slot 0 always wins the IRQ half on the next edge.
    p_slot0_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        top_irq |=> (status_word[31] && (status_word[21:16] == $past(top_id))));

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (status_word == 32'h003F_003F));

endmodule

bind prio_resolver prio_resolver_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_SRCS  (NUM_SRCS),
    .BANK_W    (BANK_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_cfg    (slot_cfg),
    .src_active  (src_active),
    .src_is_fiq  (src_is_fiq),
    .status_word (status_word)
);

// File: tb/prio_resolver_test.sv
`timescale 1ns/100ps
module prio_resolver_test;

    localparam int NUM_SLOTS = 40;
    localparam int NUM_SRCS  = 40;

    typedef struct packed {
        logic [5:0]  sa;
        logic [31:0] wa;
        logic [5:0]  sb;
        logic [31:0] wb;
        logic [63:0] act;
        logic [63:0] fiq;
        logic [31:0] exp;
    } vec_t;

    // Two programmed slots per row; every other slot stays invalid.
    localparam vec_t TBL [10] = '{
        '{6'd0,  32'h8000_0005, 6'd1, 32'h8000_0007, 64'hA0, 64'h0,  32'h8005_003F}, // R4 R6
        '{6'd0,  32'h8000_0005, 6'd1, 32'h8000_0007, 64'hA0, 64'hA0, 32'h003F_8005}, // R4 R5
        '{6'd0,  32'h8000_0005, 6'd1, 32'h8000_0007, 64'hA0, 64'h20, 32'h8007_8005}, // R4 both
        '{6'd3,  32'h8000_0026, 6'd2, 32'h8000_0006, 64'h0000_0040_0000_0000,
                                                     64'h0000_0040_0000_0000, 32'h003F_8026}, // R8
        '{6'd0,  32'h8000_0028, 6'd5, 32'h8000_0009, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h8009_003F}, // R2 range
        '{6'd0,  32'h0000_0003, 6'd1, 32'h8000_0004, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h8004_003F}, // R2 flag
        '{6'd0,  32'hBFFF_FF41, 6'd0, 32'hBFFF_FF41, 64'h2,  64'h2,  32'h003F_8001}, // R1
        '{6'd4,  32'h8000_000A, 6'd9, 32'h8000_000A, 64'h400, 64'h0, 32'h800A_003F}, // R11
        '{6'd0,  32'h0000_0000, 6'd1, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h003F_003F}, // R7
        '{6'd20, 32'h8000_0003, 6'd7, 32'h8000_001E, 64'h4000_0008, 64'h0, 32'h801E_003F}  // R3
    };

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NUM_SLOTS*32-1:0] slot_cfg;
    logic [63:0]             src_active;
    logic [63:0]             src_is_fiq;
    logic [31:0]             status_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    prio_resolver #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SRCS  (NUM_SRCS),
        .BANK_W    (32),
        .NUM_BANKS (2)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_cfg    (slot_cfg),
        .src_active  (src_active),
        .src_is_fiq  (src_is_fiq),
        .status_word (status_word)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
        checks++;
        if ((got & 32'h7FC0_7FC0) != 32'h0) begin
            errors++;
            $display("FAIL R9 reserved bits got %h expected %h", got & 32'h7FC0_7FC0, 32'h0);
        end
    endtask

    task automatic clear_inputs();
        slot_cfg   = '0;
        src_active = '0;
        src_is_fiq = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got %0d checks expected completion", checks);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clear_inputs();
        slot_cfg[31:0] = 32'h8000_0001;
        src_active     = 64'h2;
        repeat (3) @(negedge clk);
        check("R10 reset state", status_word, 32'h003F_003F);

        rst_n = 1'b1;
        @(negedge clk);
        check("R6 first result after reset", status_word, 32'h8001_003F);

        for (int i = 0; i < 10; i++) begin
            clear_inputs();
            slot_cfg[TBL[i].sa*32 +: 32] = TBL[i].wa;
            slot_cfg[TBL[i].sb*32 +: 32] = TBL[i].wb;
            src_active = TBL[i].act;
            src_is_fiq = TBL[i].fiq;
            @(negedge clk);
            check($sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R7 R8 R11)", i), status_word, TBL[i].exp);
        end

        // R10: a new input is not visible before the next edge.
        clear_inputs();
        @(negedge clk);
        slot_cfg[31:0] = 32'h8000_0002;
        src_active     = 64'h4;
        src_is_fiq     = 64'h4;
        #1;
        check("R10 holds old value before edge", status_word, 32'h003F_003F);
        @(negedge clk);
        check("R10 new value after edge", status_word, 32'h003F_8002);

        // R3: the last slot still resolves when it is the only one set.
        clear_inputs();
        slot_cfg[39*32 +: 32] = 32'h8000_0027;
        src_active = 64'h80_0000_0000;
        src_is_fiq = 64'h80_0000_0000;
        @(negedge clk);
        check("R3 R8 last slot id 39", status_word, 32'h003F_8027);

        // R3 R8: slot s holds source 39-s; activate a single source at a time.
        clear_inputs();
        for (int s = 0; s < NUM_SLOTS; s++) slot_cfg[s*32 +: 32] = 32'h8000_0000 | (39 - s);
        for (int k = 0; k < NUM_SRCS; k++) begin
            src_active = 64'h1 << k;
            @(negedge clk);
            check($sformatf("R3 R8 scan source %0d", k), status_word, 32'h8000_003F | (k << 16));
        end

        // R3 R4: all sources active, slot 0 (source 39) wins the class chosen.
        src_active = '1;
        src_is_fiq = '0;
        @(negedge clk);
        check("R3 all active IRQ", status_word, 32'h8027_003F);
        src_is_fiq = '1;
        @(negedge clk);
        check("R3 all active FIQ", status_word, 32'h003F_8027);

        // R10: reset wins over active inputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset during activity", status_word, 32'h003F_003F);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule